// File: doc/BRIEF.md
# Change-of-State Interrupt Aggregator

This block watches a bank of live status lines and latches every bit that changes value, whether it rises or falls. Each latched change flag is gated by its own enable bit. When any enabled flag is set, the block pulls a shared active-low interrupt request toward the host.

The host reads the flag word through a single read strobe. The flag word is presented on the read data port in the cycle of the strobe and is cleared at the end of that cycle. A change that arrives in the same cycle as the clearing read survives, so no event is dropped. The enable bits are written as a whole word through a write strobe.

The interrupt pad is open-drain. The logic therefore never drives it high. It exposes an output-enable, which is high when the pad is pulled low, together with a data value that is always low.

Top module: `cos_irq_agg`

## Requirements
- R1: While reset is high and in the first cycle after it, the flag word `rd_data` and the enable word are all zero and `irq_oe` is low.
- R2: A rising transition on bit i of `stat_in` sets flag i, visible on `rd_data` one clock edge after the new value is sampled.
- R3: A falling transition on bit i of `stat_in` sets flag i with the same one-edge latency as R2.
- R4: The status value present when reset is released is taken as the reference, so it never sets a flag by itself.
- R5: A set flag stays set while `rd_stat` is low, even if the status bit returns to its earlier value.
- R6: In a cycle with `rd_stat` high, `rd_data` shows the current flags, and every flag with no new change in that cycle is cleared at the clock edge.
- R7: A change on bit i in the same cycle as `rd_stat` leaves flag i set after the edge.
- R8: A cycle with `en_wr` high loads `en_wdata` into the enable word at that edge. Otherwise the enable word holds. Bit i of the enable word enables flag i.
- R9: `irq_oe` is high exactly when some flag bit and its enable bit are both 1. A flag whose enable bit is 0 still latches and reads back, but does not raise `irq_oe`.
- R10: `irq_do` is always 0, so the pad is either driven low or released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stat_in | input | N_BITS | Live status lines |
| rd_stat | input | 1 | Status read strobe; clears flags at the edge |
| rd_data | output | N_BITS | Latched change flags |
| en_wr | input | 1 | Enable word write strobe |
| en_wdata | input | N_BITS | New enable word |
| irq_oe | output | 1 | Pad output-enable; high pulls the request low |
| irq_do | output | 1 | Pad data value, constant low |

## Verification
The assertions assume that `stat_in` is synchronous to `clk`, with each new value held across a rising edge, and that `rd_stat` and `en_wr` are clean single-cycle or multi-cycle levels that are never unknown outside reset. The bench drives every input on the falling edge and holds it for at least one whole cycle, so each status change is seen at exactly one edge. The sweep goes through every pair of old and new status values on a four-bit instance, and the enable word changes with the outer loop.

// File: rtl/cos_pkg.sv
package cos_pkg;

    localparam int unsigned COS_DEF_BITS = 8;

    typedef enum logic [1:0] {
        FL_KEEP  = 2'd0,
        FL_DROP  = 2'd1,
        FL_SET   = 2'd2
    } flag_act_e;

    function automatic flag_act_e flag_action(input logic clr, input logic chg);
        if (chg)      return FL_SET;
        else if (clr) return FL_DROP;
        else          return FL_KEEP;
    endfunction

    function automatic logic flag_next(input logic cur, input flag_act_e act);
        case (act)
            FL_SET:  return 1'b1;
            FL_DROP: return 1'b0;
            default: return cur;
        endcase
    endfunction

endpackage

// File: rtl/cos_edge_detect.sv
module cos_edge_detect #(
    parameter int unsigned N_BITS = cos_pkg::COS_DEF_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_BITS-1:0] stat_in,
    output logic [N_BITS-1:0] stat_q,
    output logic              primed,
    output logic [N_BITS-1:0] chg
);
    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
            primed <= 1'b0;
        end else begin
            stat_q <= stat_in;
            primed <= 1'b1;
        end
    end

    always_comb begin
        chg = primed ? (stat_in ^ stat_q) : '0;
    end
endmodule

// File: rtl/cos_flag_bank.sv
module cos_flag_bank #(
    parameter int unsigned N_BITS = cos_pkg::COS_DEF_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_BITS-1:0] chg,
    input  logic              rd_stat,
    input  logic              en_wr,
    input  logic [N_BITS-1:0] en_wdata,
    output logic [N_BITS-1:0] flags,
    output logic [N_BITS-1:0] en_q
);
    import cos_pkg::*;

    for (genvar gi = 0; gi < N_BITS; gi++) begin : g_bit
        flag_act_e act;
        always_comb act = flag_action(rd_stat, chg[gi]);

        always_ff @(posedge clk) begin
            if (rst) flags[gi] <= 1'b0;
            else     flags[gi] <= flag_next(flags[gi], act);
        end

        always_ff @(posedge clk) begin
            if (rst)        en_q[gi] <= 1'b0;
            else if (en_wr) en_q[gi] <= en_wdata[gi];
        end
    end
endmodule

// File: rtl/cos_irq_drive.sv
module cos_irq_drive #(
    parameter int unsigned N_BITS = cos_pkg::COS_DEF_BITS
) (
    input  logic [N_BITS-1:0] flags,
    input  logic [N_BITS-1:0] en_q,
    output logic              irq_oe,
    output logic              irq_do
);
    logic [N_BITS-1:0] live;

    always_comb begin
        live   = flags & en_q;
        irq_oe = |live;
        irq_do = 1'b0;
    end
endmodule

// File: rtl/cos_irq_agg.sv
module cos_irq_agg #(
    parameter int unsigned N_BITS = cos_pkg::COS_DEF_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_BITS-1:0] stat_in,
    input  logic              rd_stat,
    output logic [N_BITS-1:0] rd_data,
    input  logic              en_wr,
    input  logic [N_BITS-1:0] en_wdata,
    output logic              irq_oe,
    output logic              irq_do
);
    logic [N_BITS-1:0] stat_q;
    logic              primed;
    logic [N_BITS-1:0] chg;
    logic [N_BITS-1:0] flags;
    logic [N_BITS-1:0] en_q;

    cos_edge_detect #(.N_BITS(N_BITS)) u_det (
        .clk    (clk),
        .rst    (rst),
        .stat_in(stat_in),
        .stat_q (stat_q),
        .primed (primed),
        .chg    (chg)
    );

    cos_flag_bank #(.N_BITS(N_BITS)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .chg     (chg),
        .rd_stat (rd_stat),
        .en_wr   (en_wr),
        .en_wdata(en_wdata),
        .flags   (flags),
        .en_q    (en_q)
    );

    cos_irq_drive #(.N_BITS(N_BITS)) u_drv (
        .flags (flags),
        .en_q  (en_q),
        .irq_oe(irq_oe),
        .irq_do(irq_do)
    );

    assign rd_data = flags;
endmodule

// File: rtl/cos_irq_agg_chk.sv
module cos_irq_agg_chk #(
    parameter int unsigned N_BITS = cos_pkg::COS_DEF_BITS
) (
    input logic              clk,
    input logic              rst,
    input logic [N_BITS-1:0] stat_in,
    input logic [N_BITS-1:0] stat_q,
    input logic              primed,
    input logic              rd_stat,
    input logic              en_wr,
    input logic [N_BITS-1:0] en_wdata,
    input logic [N_BITS-1:0] en_q,
    input logic [N_BITS-1:0] flags,
    input logic              irq_oe
);
    // R1
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (flags == '0) && (en_q == '0) && !irq_oe);

    // R2, R3: any sampled difference lands in the flags at the next edge
    a_r2_r3_change_sets: assert property (@(posedge clk) disable iff (rst)
        (primed && (stat_in != stat_q)) |=>
        ((flags & $past(stat_in ^ stat_q)) == $past(stat_in ^ stat_q)));

    // R5
    a_r5_sticky: assert property (@(posedge clk) disable iff (rst)
        !rd_stat |=> (($past(flags) & ~flags) == '0));

    // R6
    a_r6_read_clears: assert property (@(posedge clk) disable iff (rst)
        (rd_stat && primed && (stat_in == stat_q)) |=> (flags == '0));

    // R8
    a_r8_en_load: assert property (@(posedge clk) disable iff (rst)
        en_wr |=> (en_q == $past(en_wdata)));

    a_r8_en_hold: assert property (@(posedge clk) disable iff (rst)
        !en_wr |=> $stable(en_q));

    // R9
    a_r9_masked_quiet: assert property (@(posedge clk) disable iff (rst)
        ((flags & en_q) == '0) |-> !irq_oe);
endmodule

bind cos_irq_agg cos_irq_agg_chk #(.N_BITS(N_BITS)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .stat_in (stat_in),
    .stat_q  (stat_q),
    .primed  (primed),
    .rd_stat (rd_stat),
    .en_wr   (en_wr),
    .en_wdata(en_wdata),
    .en_q    (en_q),
    .flags   (flags),
    .irq_oe  (irq_oe)
);

// File: tb/test_cos_irq_agg.sv
module test_cos_irq_agg;
    localparam int unsigned NB = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NB-1:0] stat_in = '0;
    logic          rd_stat = 1'b0;
    logic [NB-1:0] rd_data;
    logic          en_wr = 1'b0;
    logic [NB-1:0] en_wdata = '0;
    logic          irq_oe;
    logic          irq_do;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cos_irq_agg #(.N_BITS(NB)) i_cos_irq_agg (
        .clk(clk), .rst(rst), .stat_in(stat_in), .rd_stat(rd_stat),
        .rd_data(rd_data), .en_wr(en_wr), .en_wdata(en_wdata),
        .irq_oe(irq_oe), .irq_do(irq_do)
    );

    task automatic chk(input string req, input logic [NB-1:0] act, input logic [NB-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic set_en(input logic [NB-1:0] v);
        en_wr = 1'b1; en_wdata = v;
        step();
        en_wr = 1'b0;
    endtask

    task automatic do_read();
        rd_stat = 1'b1;
        step();
        rd_stat = 1'b0;
    endtask

    initial begin
        logic [NB-1:0] x;
        stat_in = 4'hA;
        step(); step();
        // R1 during reset
        chk("R1 flags", rd_data, '0);
        chk("R1 irq_oe", {3'b0, irq_oe}, '0);
        rst = 1'b0;
        step();
        chk("R1 after release", rd_data, '0);
        step(); step();
        // R4: status held nonzero through release, no flag
        chk("R4 reference", rd_data, '0);
        chk("R10 pad data", {3'b0, irq_do}, '0);

        // R2 rising on bit0, masked -> R9 latched but quiet
        stat_in = 4'hB;
        step();
        chk("R2 rise", rd_data, 4'h1);
        chk("R9 masked quiet", {3'b0, irq_oe}, '0);
        // R5 sticky when status returns
        stat_in = 4'hA;
        step(); step();
        chk("R5 sticky", rd_data, 4'h1);
        // R8 enable raises request
        set_en(4'h1);
        chk("R8 enable irq", {3'b0, irq_oe}, 4'h1);
        chk("R10 pad data low", {3'b0, irq_do}, '0);
        // R6 read shows then clears
        rd_stat = 1'b1;
        #1 chk("R6 read value", rd_data, 4'h1);
        step();
        rd_stat = 1'b0;
        chk("R6 cleared", rd_data, '0);
        chk("R9 released", {3'b0, irq_oe}, '0);
        // R3 falling bit3
        stat_in = 4'h2;
        step();
        chk("R3 fall", rd_data, 4'h8);
        // R7 change coincident with read
        rd_stat = 1'b1; stat_in = 4'h3;
        step();
        rd_stat = 1'b0;
        chk("R7 coincident", rd_data, 4'h1);
        do_read();
        chk("R6 clear again", rd_data, '0);

        // Sweep: every old/new pair, enable word follows old value
        for (int a = 0; a < 16; a++) begin
            set_en(a[NB-1:0] ^ 4'h5);
            for (int b = 0; b < 16; b++) begin
                stat_in = a[NB-1:0];
                step();
                do_read();
                chk("R6 sweep clear", rd_data, '0);
                stat_in = b[NB-1:0];
                step();
                x = a[NB-1:0] ^ b[NB-1:0];
                chk("R2/R3 sweep flags", rd_data, x);
                chk("R9 sweep irq", {3'b0, irq_oe},
                    {3'b0, |(x & (a[NB-1:0] ^ 4'h5))});
            end
        end
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 100000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule